// File: doc/BRIEF.md
# Dual-Clock FIFO with Almost-Full and Almost-Empty Flags

This block is a first-in first-out buffer that connects a producer and a consumer running on unrelated clocks. The producer side has a write clock, a write enable and a data word. The consumer side has a read clock, a read enable and a data word that is valid one read-clock cycle after an accepted read. Storage is a plain inferred dual-port array. The write and read counters, the clock-domain crossing and the four status flags are ordinary logic around that array.

Each flag is driven in the clock domain that uses it. It turns on at the same clock edge that causes the condition, with no added delay. It turns off only after the opposite pointer has passed through a two-stage synchronizer, so a flag can report the buffer as fuller, or emptier, than it really is, but never the reverse. The two almost thresholds are parameters.

A global active-low reset clears both sides. A separate active-low read-side reset rewinds only the read counter to the first location, so the consumer can replay what was written since the global reset. The write counter is left as it was.

Top module: `dcfifo_flags`

## Requirements
- R1: Words come out in the order they were accepted. The word of an accepted read is on `rd_data` after the next rising edge of `rd_clk`.
- R2: `full` is 1 after the write edge that brings the occupancy to 2^ADDR_W (16 by default). A write attempted while `full` is 1 changes neither the contents nor the order of the buffer.
- R3: `empty` is 1 after the read edge that takes the last word. A read attempted while `empty` is 1 leaves `rd_data` and the read counter unchanged.
- R4: `afull` is 1 whenever the true occupancy is at or above AF_LEVEL (12 by default). Once the read side has been idle for four write cycles, `afull` is 0 when the occupancy is below AF_LEVEL.
- R5: `aempty` is 1 whenever the true occupancy is at or below AE_LEVEL (3 by default). Once the write side has been idle for four read cycles, `aempty` is 0 when the occupancy is above AE_LEVEL.
- R6: After a write into an empty buffer, `empty` is still 1 just after the first following `rd_clk` edge. It is 0 by the third following edge.
- R7: After a read from a full buffer, `full` is still 1 just after the first following `wr_clk` edge. It is 0 by the third following edge.
- R8: While `rst_n` is low, both sides return to the state `full`=0, `afull`=0, `empty`=1, `aempty`=1, with both counters at zero.
- R9: `rptr_rst_n` low at a `rd_clk` edge sets the read counter to zero and `empty` to 1. The write counter is unchanged, so the words written since the global reset are read again from the first one, and later writes follow them. Replay is valid only while no more than 2^ADDR_W words have been written since the global reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Global synchronous active-low reset, sampled in both clock domains |
| rptr_rst_n | input | 1 | Active-low reset of the read counter only, sampled on `rd_clk` |
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| wr_en | input | 1 | Write request, accepted when `full` is 0 |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request, accepted when `empty` is 0 |
| rd_data | output | DATA_W | Word from the last accepted read |
| full | output | 1 | Buffer holds 2^ADDR_W words (write domain) |
| afull | output | 1 | Occupancy at or above AF_LEVEL (write domain) |
| empty | output | 1 | Buffer holds no word (read domain) |
| aempty | output | 1 | Occupancy at or at most AE_LEVEL (read domain) |

## Verification
The hardest case to reach from the ports is a flag in its pessimistic window. In that window the opposite side has already moved, but the synchronized copy of its counter has not caught up, and the flag must still err toward the safe side. Random phases with different write and read rates cross the almost thresholds many times under two clocks whose edges never line up. On every opposite-edge sample, a queue model checks that the flag is set whenever the true occupancy requires it. Directed steps then count clock edges after a single write into an empty buffer and after a single read from a full one. A replay after a read-counter reset shows that the write side was left untouched.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Package dcf_pkg: constants shared by the dual-clock FIFO modules.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package dcf_pkg;
    // Number of flops a pointer passes through when it changes clock domain.
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Module dcf_sync: a multi-flop synchronizer for a Gray-coded bus.
// Assumes: the input changes by at most one bit per source clock, so any
// sampled value is either the old or the new code.
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = dcf_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the bus through the flop chain; clear the chain on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
// Module dcf_ram: an inferred simple dual-port array, write on one clock,
// registered read on the other.
// Assumes: the controllers never write and read the same word at once
// (full/empty gating keeps them apart). Contents are not reset.
module dcf_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed word one read-clock cycle after an accepted read.
    always_ff @(posedge rd_clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
// Module dcf_wr_ctl: the write counter and the full / almost-full flags.
// Assumes: rgray_s is the read counter in Gray code, already synchronized
// into this clock. The flags are registered from the next counter value, so
// they set on the same edge as the write that causes them.
module dcf_wr_ctl #(
    parameter int ADDR_W   = 4,
    parameter int AF_LEVEL = 12,
    localparam int PTR_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  rgray_s,
    output logic              wr_ok,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wbin,
    output logic [PTR_W-1:0]  wgray,
    output logic              full,
    output logic              afull
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);
    localparam logic [PTR_W-1:0] AF_P    = PTR_W'(AF_LEVEL);

    logic [PTR_W-1:0] rbin_s, wbin_nxt, occ_nxt;

    // Convert the synchronized Gray read counter back to binary.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign wr_ok    = wr_en && !full && rst_n;
    assign wbin_nxt = wbin + {{ADDR_W{1'b0}}, wr_ok};
    assign occ_nxt  = wbin_nxt - rbin_s;
    assign waddr    = wbin[ADDR_W-1:0];

    // Advance the counter and register the write-side flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
            afull <= 1'b0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
            full  <= (occ_nxt == DEPTH_P);
            afull <= (occ_nxt >= AF_P);
        end
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
// Module dcf_rd_ctl: the read counter and the empty / almost-empty flags.
// Assumes: wgray_s is the write counter in Gray code, already synchronized
// into this clock. ptr_rst_n rewinds only this counter; the flags are forced
// to their safe value for that cycle.
module dcf_rd_ctl #(
    parameter int ADDR_W   = 4,
    parameter int AE_LEVEL = 3,
    localparam int PTR_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_rst_n,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  wgray_s,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rbin,
    output logic [PTR_W-1:0]  rgray,
    output logic              empty,
    output logic              aempty
);
    localparam logic [PTR_W-1:0] AE_P = PTR_W'(AE_LEVEL);

    logic [PTR_W-1:0] wbin_s, rbin_nxt, occ_nxt;

    // Convert the synchronized Gray write counter back to binary.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign rd_ok    = rd_en && !empty && ptr_rst_n && rst_n;
    assign rbin_nxt = rbin + {{ADDR_W{1'b0}}, rd_ok};
    assign occ_nxt  = wbin_s - rbin_nxt;
    assign raddr    = rbin[ADDR_W-1:0];

    // Advance or rewind the counter and register the read-side flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !ptr_rst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            empty  <= 1'b1;
            aempty <= 1'b1;
        end else begin
            rbin   <= rbin_nxt;
            rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
            empty  <= (occ_nxt == '0);
            aempty <= (occ_nxt <= AE_P);
        end
    end
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/1ps
// Module dcfifo_flags: a dual-clock FIFO with full, almost-full, empty and
// almost-empty flags that set at once and clear after synchronization.
// Assumes: rst_n is held low for several cycles of both clocks, and
// rptr_rst_n is used only while at most 2^ADDR_W words were written since
// the global reset.
module dcfifo_flags #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int AF_LEVEL = 12,
    parameter int AE_LEVEL = 3
) (
    input  logic              rst_n,
    input  logic              rptr_rst_n,
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              afull,
    output logic              empty,
    output logic              aempty
);
    localparam int PTR_W = ADDR_W + 1;

    logic              wr_ok, rd_ok;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wbin, wgray, rbin, rgray, wgray_r, rgray_w;

    dcf_wr_ctl #(.ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rgray_s(rgray_w),
        .wr_ok(wr_ok), .waddr(waddr), .wbin(wbin), .wgray(wgray),
        .full(full), .afull(afull)
    );

    dcf_rd_ctl #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .ptr_rst_n(rptr_rst_n), .rd_en(rd_en),
        .wgray_s(wgray_r), .rd_ok(rd_ok), .raddr(raddr), .rbin(rbin),
        .rgray(rgray), .empty(empty), .aempty(aempty)
    );

    dcf_sync #(.W(PTR_W)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
    );

    dcf_sync #(.W(PTR_W)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
    );

    dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .re(rd_ok), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/dcfifo_flags_chk.sv
`timescale 1ns/1ps
// Module dcfifo_flags_chk: property checks on the FIFO counters and flags,
// attached to every dcfifo_flags instance by the bind below.
// Assumes: both resets are active low and sampled synchronously.
module dcfifo_flags_chk #(
    parameter int ADDR_W   = 4,
    localparam int PTR_W   = ADDR_W + 1
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             rptr_rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             full,
    input logic             afull,
    input logic             empty,
    input logic             aempty,
    input logic [PTR_W-1:0] wbin,
    input logic [PTR_W-1:0] wgray,
    input logic [PTR_W-1:0] rbin,
    input logic [PTR_W-1:0] rgray,
    input logic [PTR_W-1:0] rgray_w
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);
    logic [PTR_W-1:0] rb_w;

    // Decode the read counter as the write side sees it.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) rb_w[i] = ^(rgray_w >> i);
    end

    assert_full_blocks_write_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wbin));

    assert_wside_no_overflow_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (PTR_W'(wbin - rb_w) <= DEPTH_P));

    assert_empty_blocks_read_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_en && rptr_rst_n) |=> $stable(rbin));

    assert_full_implies_afull_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> afull);

    assert_empty_implies_aempty_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> aempty);

    assert_wgray_onestep_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_onestep_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rptr_rst_n |=> ($countones(rgray ^ $past(rgray)) <= 1));

    assert_ptr_rewind_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rptr_rst_n |=> (rbin == '0 && empty));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .rptr_rst_n(rptr_rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .full(full), .afull(afull), .empty(empty),
    .aempty(aempty), .wbin(wbin), .wgray(wgray), .rbin(rbin), .rgray(rgray),
    .rgray_w(rgray_w)
);

// File: tb/sim_dcfifo_flags.sv
`timescale 1ns/1ps
// Bench for dcfifo_flags: directed corner cases plus seeded random traffic,
// checked against a queue model of the buffer contents.
module sim_dcfifo_flags;
    localparam int DW = 8, AW = 4, DEPTH = 16, AF = 12, AE = 3;

    logic wr_clk = 0, rd_clk = 0, rst_n = 0, rptr_rst_n = 1;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic full, afull, empty, aempty;

    int nchk = 0, nfail = 0;
    bit mon_on = 0, done = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] hist[$];

    dcfifo_flags #(.DATA_W(DW), .ADDR_W(AW), .AF_LEVEL(AF), .AE_LEVEL(AE)) u0 (
        .rst_n(rst_n), .rptr_rst_n(rptr_rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .full(full), .afull(afull), .empty(empty), .aempty(aempty)
    );

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #6.85 rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_cycle(input bit en, input logic [DW-1:0] d);
        bit acc;
        @(negedge wr_clk);
        wr_en = en;
        wr_data = d;
        acc = en && !full;
        @(posedge wr_clk);
        if (acc) begin
            q.push_back(d);
            hist.push_back(d);
        end
        #1 wr_en = 0;
    endtask

    task automatic rd_cycle(input bit en);
        bit acc;
        logic [DW-1:0] e;
        e = '0;
        @(negedge rd_clk);
        rd_en = en;
        acc = en && !empty;
        @(posedge rd_clk);
        if (acc) e = q.pop_front();
        #1 rd_en = 0;
        if (acc) begin
            @(negedge rd_clk);
            chk(rd_data == e, "R1 data order", int'(rd_data), int'(e));
        end
    endtask

    // Write-side flags must never under-report the true occupancy.
    always @(negedge wr_clk) begin
        if (mon_on) begin
            if (q.size() == DEPTH) chk(full == 1'b1, "R2 full", int'(full), 1);
            if (q.size() >= AF) chk(afull == 1'b1, "R4 afull", int'(afull), 1);
        end
    end

    // Read-side flags must never under-report the true emptiness.
    always @(negedge rd_clk) begin
        if (mon_on) begin
            if (q.size() == 0) chk(empty == 1'b1, "R3 empty", int'(empty), 1);
            if (q.size() <= AE) chk(aempty == 1'b1, "R5 aempty", int'(aempty), 1);
        end
    end

    initial begin
        #1_600_000;
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [DW-1:0] hold;
        seed = $urandom(32'd1729);

        // R8: global reset
        repeat (6) @(posedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1;
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk);
        chk(full == 0, "R8 full", int'(full), 0);
        chk(afull == 0, "R8 afull", int'(afull), 0);
        @(negedge rd_clk);
        chk(empty == 1, "R8 empty", int'(empty), 1);
        chk(aempty == 1, "R8 aempty", int'(aempty), 1);
        mon_on = 1;

        // R6: empty releases late after a single write
        wr_cycle(1, 8'hA5);
        @(posedge rd_clk); #1;
        chk(empty == 1, "R6 empty held", int'(empty), 1);
        repeat (2) @(posedge rd_clk);
        #1;
        chk(empty == 0, "R6 empty released", int'(empty), 0);
        chk(aempty == 1, "R5 aempty at one word", int'(aempty), 1);
        rd_cycle(1);

        // R9: read-counter rewind replays all words since reset
        for (int i = 0; i < 5; i++) wr_cycle(1, 8'hB0 + 8'(i));
        repeat (4) @(posedge rd_clk);
        rd_cycle(1);
        rd_cycle(1);
        @(negedge rd_clk);
        rptr_rst_n = 0;
        @(posedge rd_clk);
        q = hist;
        #1 rptr_rst_n = 1;
        @(negedge rd_clk);
        chk(empty == 1, "R9 empty after rewind", int'(empty), 1);
        chk(q.size() == 6, "R9 replay length", q.size(), 6);
        for (int g = 0; g < 200 && q.size() > 0; g++) rd_cycle(1);
        wr_cycle(1, 8'hC3);
        repeat (4) @(posedge rd_clk);
        for (int g = 0; g < 50 && q.size() > 0; g++) rd_cycle(1);
        chk(q.size() == 0, "R9 write counter kept", q.size(), 0);

        // R2 / R4: fill to full with exact flag timing
        repeat (5) @(posedge wr_clk);
        for (int i = 0; i < DEPTH; i++) begin
            wr_cycle(1, 8'h40 + 8'(i));
            chk(afull == (i + 1 >= AF), "R4 afull exact", int'(afull), int'(i + 1 >= AF));
            if (i == DEPTH - 2) chk(full == 0, "R2 full early", int'(full), 0);
        end
        chk(full == 1, "R2 full on last write", int'(full), 1);
        wr_cycle(1, 8'hEE);
        chk(full == 1, "R2 write while full", int'(full), 1);
        chk(q.size() == DEPTH, "R2 write while full", q.size(), DEPTH);

        // R7: full releases late after a single read
        rd_cycle(1);
        @(posedge wr_clk); #1;
        chk(full == 1, "R7 full held", int'(full), 1);
        repeat (2) @(posedge wr_clk);
        #1;
        chk(full == 0, "R7 full released", int'(full), 0);
        repeat (4) @(negedge rd_clk);
        chk(aempty == 0, "R5 aempty released", int'(aempty), 0);

        // R3: drain, then read while empty
        for (int g = 0; g < 200 && q.size() > 0; g++) rd_cycle(1);
        chk(empty == 1, "R3 empty on last read", int'(empty), 1);
        @(negedge rd_clk);
        hold = rd_data;
        rd_cycle(1);
        @(negedge rd_clk);
        chk(rd_data == hold, "R3 read while empty", int'(rd_data), int'(hold));
        chk(empty == 1, "R3 still empty", int'(empty), 1);

        // Random traffic: write-heavy, then read-heavy
        fork
            for (int i = 0; i < 400; i++) wr_cycle(($urandom % 100) < 70, 8'($urandom));
            for (int i = 0; i < 250; i++) rd_cycle(($urandom % 100) < 45);
        join
        fork
            for (int i = 0; i < 300; i++) wr_cycle(($urandom % 100) < 30, 8'($urandom));
            for (int i = 0; i < 400; i++) rd_cycle(($urandom % 100) < 85);
        join
        for (int g = 0; g < 2000 && q.size() > 0; g++) rd_cycle(1);
        chk(q.size() == 0, "R1 drained", q.size(), 0);

        // R4 / R5: quiet state after drain
        repeat (6) @(posedge rd_clk);
        @(negedge wr_clk);
        chk(full == 0, "R2 full idle", int'(full), 0);
        chk(afull == 0, "R4 afull idle", int'(afull), 0);
        @(negedge rd_clk);
        chk(empty == 1, "R3 empty idle", int'(empty), 1);
        chk(aempty == 1, "R5 aempty idle", int'(aempty), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule